// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a synchronous host read and write an external asynchronous static RAM of 1,048,576 words by 4 bits. The host raises a request carrying a 20-bit word address, a write flag and 4 bits of write data. It keeps the request raised until an acknowledge pulse returns. A read also returns 4 bits of data.

On the memory side the controller drives active-low chip select, read enable and write strobe lines and the address bus. It also drives a split data bus made of out, drive-enable and in signals. Every memory pin is a register output. The pins follow the part's control truth table: a deselected part floats its data pins, and a low write strobe means a write even when read enable is low.

The number of wait cycles is worked out during elaboration. It comes from the clock period, a speed-grade parameter (20, 25 or 35 ns parts) and the write setup and pulse widths. Each time is rounded up to whole clock cycles.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low and on the first edges after it, chip select, read enable and write strobe are high, the data-bus drive enable is low and acknowledge is low.
- R2: A read holds chip select and read enable low, the write strobe high and the address unchanged for exactly RD cycles. RD is the larger of the address-access time and the read-enable access time, divided by the clock period and rounded up. The read-access time is 20, 25 or 35 ns for grades 20, 25 and 35; any other grade value falls back to 35.
- R3: Acknowledge is high for one cycle per transaction. For a read it rises on the RD-th edge after the accepting edge, which makes it the (RD+1)-th edge after the request is first raised.
- R4: Read data is captured from the data-in bus on the edge that ends the read. It stays unchanged until the next read completes.
- R5: A write drives the data bus for SU setup cycles with chip select low and the strobe high, then holds the strobe low for PW cycles, then keeps one hold cycle with the strobe high and the bus still driven. SU and PW are the setup and pulse times rounded up to cycles. Acknowledge rises on the edge that ends the hold cycle, SU+PW+2 edges after the request is raised.
- R6: The data-bus drive enable is never high while read enable is low, and the write strobe is never low while chip select is high.
- R7: A write accepted when the previous accepted transaction was a read first spends TURN cycles with every control line high and the bus released. This adds TURN cycles to its latency. TURN is the grade's float time (9, 10 or 12 ns) rounded up to cycles, with a minimum of 1.
- R8: The data-bus drive enable rises no sooner than the float time, in whole cycles, after read enable was last high-going.
- R9: A write after a write, and a read after any transaction, start on the accepting edge with no turnaround cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held until acknowledge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Last read data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 20 | Memory address bus |
| mem_dq_out | output | 4 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 4 | Data from memory |

## Verification
Two things can meet in the same clock: a read completes (data capture, read enable released, acknowledge) while the host already presents a write. That write must then start with the turnaround gap, not with the bus drive. The bench provokes this by raising the next request on the same half-cycle in which it sees acknowledge. The test pattern includes read-then-write pairs and a random mix. A behavioural memory model returns corrupted data until the access time has passed, tracks how long the part keeps driving the bus, and checks every clock that the drive enable stays low during that window. Latencies and read data are compared with values the bench computes itself.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WSU,
    ST_WPW,
    ST_WHOLD
  } ctl_state_e;

  // Read access time (address and chip-select access are equal per grade)
  function automatic int grade_access_ns(input int grade);
    case (grade)
      20:      return 20;
      25:      return 25;
      default: return 35;
    endcase
  endfunction

  // Read-enable to valid data
  function automatic int grade_oe_ns(input int grade);
    case (grade)
      20:      return 6;
      25:      return 8;
      default: return 10;
    endcase
  endfunction

  // Time the part may keep driving after it is released
  function automatic int grade_float_ns(input int grade);
    case (grade)
      20:      return 9;
      25:      return 10;
      default: return 12;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Round a time up to whole clocks, never less than one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int TURN_CYC = 1,
  parameter int SU_CYC   = 1,
  parameter int PW_CYC   = 2,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_wr,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             ack
);
  ctl_state_e st_q, st_nx;
  logic       last_rd_q;
  logic       done;

  always_comb begin
    st_nx    = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    done     = 1'b0;
    case (st_q)
      ST_IDLE: if (req) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (!req_wr) begin
          st_nx   = ST_READ;
          tmr_val = CNT_W'(RD_CYC - 1);
        end else if (last_rd_q) begin
          st_nx   = ST_TURN;
          tmr_val = CNT_W'(TURN_CYC - 1);
        end else begin
          st_nx   = ST_WSU;
          tmr_val = CNT_W'(SU_CYC - 1);
        end
      end
      ST_READ: if (tmr_zero) begin
        capture = 1'b1;
        done    = 1'b1;
        st_nx   = ST_IDLE;
      end
      ST_TURN: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SU_CYC - 1);
        st_nx    = ST_WSU;
      end
      ST_WSU: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PW_CYC - 1);
        st_nx    = ST_WPW;
      end
      ST_WPW: if (tmr_zero) st_nx = ST_WHOLD;
      ST_WHOLD: begin
        done  = 1'b1;
        st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  // Pins are registered and decoded from the next state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      last_rd_q <= 1'b0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      ack       <= 1'b0;
    end else begin
      st_q  <= st_nx;
      if (accept) last_rd_q <= !req_wr;
      ce_n  <= !(st_nx inside {ST_READ, ST_WSU, ST_WPW, ST_WHOLD});
      oe_n  <= (st_nx != ST_READ);
      we_n  <= (st_nx != ST_WPW);
      dq_oe <= (st_nx inside {ST_WSU, ST_WPW, ST_WHOLD});
      ack   <= done;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 4,
  parameter int CLK_NS      = 10,
  parameter int GRADE_NS    = 20,
  parameter int WR_SETUP_NS = 10,
  parameter int WR_PULSE_NS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_CYC   = ns_to_cyc(max2(grade_access_ns(GRADE_NS), grade_oe_ns(GRADE_NS)), CLK_NS);
  localparam int TURN_CYC = ns_to_cyc(grade_float_ns(GRADE_NS), CLK_NS);
  localparam int SU_CYC   = ns_to_cyc(WR_SETUP_NS, CLK_NS);
  localparam int PW_CYC   = ns_to_cyc(WR_PULSE_NS, CLK_NS);
  localparam int MAX_CYC  = max2(max2(RD_CYC, TURN_CYC), max2(SU_CYC, PW_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  // Named internal events, used by the bound checker
  logic             accept;
  logic             capture;
  logic             tmr_load;
  logic             tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  sram_ctl_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_ctl_seq #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .SU_CYC   (SU_CYC),
    .PW_CYC   (PW_CYC),
    .CNT_W    (CNT_W)
  ) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_wr   (req_wr),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .accept   (accept),
    .capture  (capture),
    .ce_n     (mem_ce_n),
    .oe_n     (mem_oe_n),
    .we_n     (mem_we_n),
    .dq_oe    (mem_dq_oe),
    .ack      (ack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= mem_dq_in;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rdata      = rdata_q;
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int CLK_NS   = 10,
  parameter int GRADE_NS = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr,
  input logic              capture
);
  localparam int FLOAT_CYC = ns_to_cyc(grade_float_ns(GRADE_NS), CLK_NS);

  // Cycles since read enable was last low, saturating
  logic [7:0] quiet_q;
  always_ff @(posedge clk) begin
    if (!rst_n)             quiet_q <= 8'hFF;
    else if (!oe_n)         quiet_q <= 8'd0;
    else if (quiet_q != 8'hFF) quiet_q <= quiet_q + 8'd1;
  end

  p_strobe_needs_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);
  p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
  p_strobe_with_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && oe_n));
  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> (addr == $past(addr)));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (!ce_n && dq_oe));
  p_float_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (int'(quiet_q) >= FLOAT_CYC));
  p_capture_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> ack);
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .CLK_NS   (CLK_NS),
  .GRADE_NS (GRADE_NS)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .ack     (ack),
  .ce_n    (mem_ce_n),
  .oe_n    (mem_oe_n),
  .we_n    (mem_we_n),
  .dq_oe   (mem_dq_oe),
  .addr    (mem_addr),
  .capture (capture)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GRADE      = 25;
  localparam int SETUP_NS   = 10;
  localparam int PULSE_NS   = 20;

  function automatic int to_cyc(input int ns);
    int c = 0;
    while (c * CLK_PERIOD < ns) c++;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Grade 25: access 25 ns, read-enable access 8 ns, float 10 ns
  localparam int ACC_NS   = (GRADE == 20) ? 20 : (GRADE == 25) ? 25 : 35;
  localparam int FLT_NS   = (GRADE == 20) ? 9  : (GRADE == 25) ? 10 : 12;
  int rd_exp, flt_exp, su_exp, pw_exp;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        ack;
  logic [3:0]  rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [19:0] mem_addr;
  logic [3:0]  mem_dq_out;
  logic [3:0]  mem_dq_in = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctl #(
    .CLK_NS(CLK_PERIOD), .GRADE_NS(GRADE),
    .WR_SETUP_NS(SETUP_NS), .WR_PULSE_NS(PULSE_NS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req_tag, act, exp, $time);
    end
  endtask

  // Behavioural memory and scoreboard
  logic [3:0] mem [int];
  logic [3:0] exp_mem [int];
  logic [3:0] exp_rdata = '0;
  bit         last_rd = 0;

  // Per-clock monitor state
  int   acc = 0, quiet = 100, su_cnt = 0, pw_cnt = 0;
  logic prev_rd = 0, prev_ce = 1, prev_we = 1, prev_ack = 0;
  logic [19:0] prev_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic rd_now;
      logic [3:0] mv;
      rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (rd_now) acc = (prev_rd && mem_addr == prev_addr) ? acc + 1 : 1;
      else        acc = 0;
      quiet = rd_now ? 0 : ((quiet < 100) ? quiet + 1 : quiet);
      mv = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 4'h0;
      mem_dq_in = (rd_now && acc >= rd_exp) ? mv : ~mv;
      // R8: bus drive only after the float window
      if (mem_dq_oe) check(quiet >= flt_exp + 1, "R8", quiet, flt_exp + 1);
      // R6: control truth table
      check(!(!mem_oe_n && mem_dq_oe), "R6", mem_dq_oe, 0);
      check(!(!mem_we_n && mem_ce_n), "R6", mem_ce_n, 0);
      // R2/R5: address stable while selected
      if (!mem_ce_n && !prev_ce) check(mem_addr == prev_addr, "R2", mem_addr, prev_addr);
      // R3: single-cycle acknowledge
      if (ack) check(!prev_ack, "R3", prev_ack, 0);
      // R4: read data held between read completions
      if (!ack) check(rdata == exp_rdata, "R4", rdata, exp_rdata);
      // R5: setup and pulse widths, memory write at strobe rise
      if (mem_ce_n) su_cnt = 0;
      else if (mem_dq_oe && mem_we_n && prev_we) su_cnt++;
      if (prev_we && !mem_we_n) begin
        check(su_cnt == su_exp, "R5", su_cnt, su_exp);
        pw_cnt = 1;
      end else if (!mem_we_n) pw_cnt++;
      if (!prev_we && mem_we_n) begin
        check(pw_cnt == pw_exp, "R5", pw_cnt, pw_exp);
        check(!mem_ce_n && mem_dq_oe, "R5", {mem_ce_n, mem_dq_oe}, 2'b01);
        mem[int'(mem_addr)] = mem_dq_out;
      end
      prev_rd = rd_now; prev_ce = mem_ce_n; prev_we = mem_we_n;
      prev_ack = ack; prev_addr = mem_addr;
    end
  end

  // Issue one transaction; caller is at a negedge
  task automatic txn(input bit wr, input logic [19:0] a, input logic [3:0] d, input string tag);
    int n = 0;
    int exp_lat;
    exp_lat = wr ? (su_exp + pw_exp + 2 + (last_rd ? flt_exp : 0)) : (rd_exp + 1);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!ack && n < 100);
    req = 1'b0;
    check(n == exp_lat, tag, n, exp_lat);
    if (wr) exp_mem[int'(a)] = d;
    else begin
      logic [3:0] e;
      e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 4'h0;
      check(rdata == e, "R4", rdata, e);
      exp_rdata = e;
    end
    last_rd = !wr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rd_exp  = to_cyc(ACC_NS);
    flt_exp = to_cyc(FLT_NS);
    su_exp  = to_cyc(SETUP_NS);
    pw_exp  = to_cyc(PULSE_NS);
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(!mem_dq_oe && !ack, "R1", {mem_dq_oe, ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(!mem_dq_oe && !ack, "R1", {mem_dq_oe, ack}, 0);

    txn(1, 20'h00000, 4'h5, "R5 first write");
    txn(1, 20'hFFFFF, 4'hA, "R9 write after write");
    txn(0, 20'h00000, 4'h0, "R2 R3 read low");
    txn(0, 20'hFFFFF, 4'h0, "R3 back-to-back read");
    txn(1, 20'h12345, 4'h3, "R7 write after read");
    txn(0, 20'h12345, 4'h0, "R9 read after write");
    idle(5);
    txn(0, 20'h0BEEF, 4'h0, "R2 unwritten read");
    idle(3);
    txn(1, 20'h0BEEF, 4'hC, "R7 write after idle read");
    txn(0, 20'h0BEEF, 4'h0, "R4 readback");
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 60; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        txn(lf[0], {lf[3:1], 17'h1F0F0}, lf[7:4], lf[0] ? "R7 R9 mixed write" : "R2 mixed read");
        if (lf[9:8] == 2'b00) idle(2);
      end
    end
    idle(4);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule